// File: doc/BRIEF.md
# Ultraviolet-Erasable Byte Memory Model with Identifier Readout

This block is a synthesizable stand-in for a byte-wide, ultraviolet-erasable programmable memory. It is meant to be the device under test for a programming sequencer. It follows the part's pin-level operating modes, with every analog condition reduced to a digital flag:

- `vpp_hi` means the programming supply is raised.
- `vcc_prog` means the core supply is at the programming level.
- `a9_hv` means high voltage is applied to the identifier-select address line.

The block decodes these modes from the flags and the active-low enables:

- normal read;
- output disable;
- standby;
- program;
- program verify;
- program inhibit;
- identifier readout.

Physical erasure is replaced by a one-cycle bulk-erase strobe. The block has no timing delays. Every observable result is registered, so it appears one clock after the inputs that cause it. A program pulse can only clear bits. A sequencer or bench can therefore model cells that need several pulses by choosing which bits each pulse is allowed to clear.

The array depth is set by `ADDR_W`. The default is 12 bits (4096 bytes). Setting `ADDR_W` to 16 gives the full 64 K-byte organisation.

Top module: `eprom_model`

## Requirements
- R1: After reset, and after any bulk erase, every byte of the array reads 0xFF. While reset is held, `data_oe` is 0.
- R2: Normal read is `ce_n`=0, `oe_n`=0, `vpp_hi`=0, `a9_hv`=0 and `vcc_prog`=0. In this mode, one clock after the inputs are presented, `data_oe` is 1 and `data_out` holds the byte stored at `addr`.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, the outputs float one clock later: `data_oe`=0 and `data_out`=0x00.
- R4: With `ce_n`=1 and `vpp_hi`=0 (standby), the outputs float one clock later, whatever the value of `oe_n`.
- R5: A program pulse is a 1-to-0 transition of `ce_n` while `vpp_hi`=1 and `vcc_prog`=1. Each such transition performs exactly one write, at the clock where `ce_n` is first sampled low. Holding `ce_n` low does not write again. While `vpp_hi`=1, the outputs float.
- R6: A program write stores `old AND data_in`. Bits can only go from 1 to 0; a later pulse can never set a cleared bit.
- R7: With `vpp_hi`=1 and `ce_n`=1 (program inhibit), or with `vpp_hi`=1 and `vcc_prog`=0, the array is left unchanged and the outputs float.
- R8: Program verify is `vcc_prog`=1, `vpp_hi`=0, `ce_n`=0, `oe_n`=0. In this mode the stored byte at `addr` is driven one clock later, exactly as in read.
- R9: Identifier readout is `a9_hv`=1, `ce_n`=0, `oe_n`=0, `vpp_hi`=0, with a clean address. In this mode, `addr[0]`=0 drives the maker code 0x04 and `addr[0]`=1 drives the device code 0xE3, one clock later.
- R10: In identifier readout, address bits 1 to 8, and bits 10 to 13 where present, must all be 0. If any of them is 1, the outputs float. Address bits 9, 14 and 15 are ignored.
- R11: A one-cycle `erase`=1 sets every byte to 0xFF at that clock edge. It is ignored while `vpp_hi`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Byte to program |
| data_out | output | 8 | Driven byte, 0x00 when floating |
| data_oe | output | 1 | Output drive enable of the data bus |
| ce_n | input | 1 | Chip enable, active low; its falling edge is the program pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply raised |
| vcc_prog | input | 1 | Core supply at programming level |
| a9_hv | input | 1 | High voltage on the identifier-select line |
| erase | input | 1 | Bulk-erase strobe, one cycle |

## Verification
Every output result (read data, verify data, identifier bytes and the float state) is due exactly one clock after the inputs that select it. The bench changes inputs on the falling edge and samples on the next falling edge, half a period after the capturing rising edge.

A program write or an erase takes effect on the rising edge where its condition is first sampled. It is therefore checked by a read that is presented on the following cycle and sampled one cycle after that.

Random operations run against a bench reference array that ANDs each programmed byte. Directed cases cover:
- repeated pulses while `ce_n` stays low;
- an erase blocked by `vpp_hi`;
- identifier reads with ignored and with forbidden address bits set.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_DISABLE,
    MD_READ,
    MD_VERIFY,
    MD_SIG,
    MD_SIGBAD,
    MD_PROG,
    MD_INHIBIT
  } mode_e;

  localparam logic [BYTE_W-1:0] ID_MAKER  = 8'h04;
  localparam logic [BYTE_W-1:0] ID_DEVICE = 8'hE3;

  // identifier mode needs address lines 1..8 and 10..13 low
  function automatic logic sig_addr_clean(input logic [15:0] a);
    return (a[8:1] == 8'h00) && (a[13:10] == 4'h0);
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic sel);
    return sel ? ID_DEVICE : ID_MAKER;
  endfunction

  // a pulse can only pull cells from 1 to 0
  function automatic logic [BYTE_W-1:0] burn(input logic [BYTE_W-1:0] old,
                                             input logic [BYTE_W-1:0] din);
    return old & din;
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              vcc_prog,
  input  logic              a9_hv,
  output mode_e             mode,
  output logic              pgm_fire
);

  logic [15:0] addr_x;
  logic        ce_n_q;

  assign addr_x = 16'(addr);

  always_comb begin
    if (vpp_hi) begin
      if (!ce_n && vcc_prog) mode = MD_PROG;
      else                   mode = MD_INHIBIT;
    end else if (ce_n) begin
      mode = MD_STANDBY;
    end else if (oe_n) begin
      mode = MD_DISABLE;
    end else if (a9_hv) begin
      mode = sig_addr_clean(addr_x) ? MD_SIG : MD_SIGBAD;
    end else if (vcc_prog) begin
      mode = MD_VERIFY;
    end else begin
      mode = MD_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_n_q <= 1'b1;
    else        ce_n_q <= ce_n;
  end

  // write only on the first sampled-low cycle of chip enable
  assign pgm_fire = (mode == MD_PROG) && ce_n_q;

  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_fire |=> !pgm_fire);

endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  input  logic              pgm_fire,
  input  logic              erase_req,
  input  logic              vpp_hi,
  output logic [BYTE_W-1:0] rd_q,
  output logic [BYTE_W-1:0] cell_now
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic              erase_fire;

  assign erase_fire = erase_req && !vpp_hi;
  assign cell_now   = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase_fire) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (pgm_fire) begin
      mem[addr] <= burn(mem[addr], din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '1;
    else        rd_q <= mem[addr];
  end

  a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_fire |=> (!$stable(addr) || ((cell_now & ~$past(cell_now)) == '0)));

  a_r11_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> (cell_now == '1));

endmodule

// File: rtl/eprom_outsel.sv
module eprom_outsel
  import eprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              a0,
  input  logic [BYTE_W-1:0] rd_q,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_oe
);

  logic              drive_q;
  logic              sig_q;
  logic [BYTE_W-1:0] id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      sig_q   <= 1'b0;
      id_q    <= '0;
    end else begin
      drive_q <= (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_SIG);
      sig_q   <= (mode == MD_SIG);
      id_q    <= id_byte(a0);
    end
  end

  assign data_oe  = drive_q;
  assign data_out = !drive_q ? '0 : (sig_q ? id_q : rd_q);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_READ) || (mode == MD_VERIFY)) |=> (data_oe && data_out == rd_q));

  a_r4_float_modes: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_STANDBY) || (mode == MD_DISABLE) || (mode == MD_SIGBAD) ||
     (mode == MD_PROG) || (mode == MD_INHIBIT)) |=> (!data_oe && data_out == '0));

  a_r9_sig_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SIG) |=> (data_oe && data_out == id_byte($past(a0))));

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              vcc_prog,
  input  logic              a9_hv,
  input  logic              erase
);

  mode_e             mode;
  logic              pgm_fire;
  logic [BYTE_W-1:0] rd_q;
  logic [BYTE_W-1:0] cell_now;

  eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .vpp_hi   (vpp_hi),
    .vcc_prog (vcc_prog),
    .a9_hv    (a9_hv),
    .mode     (mode),
    .pgm_fire (pgm_fire)
  );

  eprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .din       (data_in),
    .pgm_fire  (pgm_fire),
    .erase_req (erase),
    .vpp_hi    (vpp_hi),
    .rd_q      (rd_q),
    .cell_now  (cell_now)
  );

  eprom_outsel u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .a0       (addr[0]),
    .rd_q     (rd_q),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

  a_r7_vpp_float: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |=> !data_oe);

endmodule

// File: tb/tb_eprom_model.sv
module tb_eprom_model;

  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data_in = 8'hFF;
  logic [7:0]    data_out;
  logic          data_oe;
  logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, vcc_prog = 1'b0;
  logic          a9_hv = 1'b0, erase = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  eprom_model #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .vcc_prog(vcc_prog), .a9_hv(a9_hv), .erase(erase)
  );

  // identifier bytes rebuilt from the bit lists, O0 first
  function automatic logic [7:0] exp_id(input logic sel);
    bit maker [8] = '{0, 0, 1, 0, 0, 0, 0, 0};
    bit devc  [8] = '{1, 1, 0, 0, 0, 1, 1, 1};
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = sel ? devc[i] : maker[i];
    return v;
  endfunction

  function automatic bit exp_sig_ok(input logic [AW-1:0] a);
    for (int i = 1; i < 14; i++)
      if (i != 9 && i < AW && a[i]) return 0;
    return 1;
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic idle;
    ce_n = 1; oe_n = 1; vpp_hi = 0; vcc_prog = 0; a9_hv = 0; erase = 0;
  endtask

  task automatic check(input string req, input logic oe_e, input logic [7:0] d_e);
    checks++;
    if (data_oe !== oe_e || data_out !== d_e) begin
      errors++;
      $display("FAIL %s: got oe=%b data=%02h, expected oe=%b data=%02h",
               req, data_oe, data_out, oe_e, d_e);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic verify, input string req);
    idle(); addr = a; ce_n = 0; oe_n = 0; vcc_prog = verify;
    tick();
    check(req, 1'b1, model[a]);
  endtask

  task automatic do_program(input logic [AW-1:0] a, input logic [7:0] d,
                            input logic vcc, input int hold);
    idle(); addr = a; data_in = d; vpp_hi = 1; vcc_prog = vcc;
    tick();
    ce_n = 0;
    for (int i = 0; i < hold; i++) tick();
    check("R5 float during program", 1'b0, 8'h00);
    ce_n = 1;
    tick();
    if (vcc) model[a] = model[a] & d;
  endtask

  task automatic do_sig(input logic [AW-1:0] a, input string req);
    idle(); addr = a; a9_hv = 1; ce_n = 0; oe_n = 0;
    tick();
    if (exp_sig_ok(a)) check(req, 1'b1, exp_id(a[0]));
    else               check(req, 1'b0, 8'h00);
  endtask

  task automatic do_erase(input logic with_vpp);
    idle(); erase = 1; vpp_hi = with_vpp;
    tick();
    idle();
    if (!with_vpp) for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    void'($urandom(32'h5EED_0427));
    idle();
    tick(); tick();
    check("R1 reset float", 1'b0, 8'h00);
    rst_n = 1;
    tick();
    check("R4 standby after reset", 1'b0, 8'h00);
    do_read(12'h005, 0, "R1 erased read");
    do_read(12'hFFF, 0, "R1 erased top");

    // R3 and R4 floats
    idle(); ce_n = 0; oe_n = 1; addr = 12'h005; tick();
    check("R3 output disable", 1'b0, 8'h00);
    idle(); ce_n = 1; oe_n = 0; tick();
    check("R4 standby ignores oe", 1'b0, 8'h00);

    // R6 clear-only across pulses
    do_program(12'h010, 8'h0F, 1, 1);
    do_read(12'h010, 1, "R8 verify after pulse");
    do_program(12'h010, 8'hF0, 1, 1);
    do_read(12'h010, 0, "R6 bits never set");

    // R5 held low gives one write only (AND is idempotent, so use inhibit-style check via repeat count)
    do_program(12'h020, 8'hAA, 1, 5);
    do_read(12'h020, 0, "R5 held pulse");

    // R7 no write without programming Vcc, and inhibit
    do_program(12'h030, 8'h00, 0, 1);
    do_read(12'h030, 0, "R7 no write without vcc_prog");
    idle(); vpp_hi = 1; vcc_prog = 1; addr = 12'h031; data_in = 8'h00; tick(); tick();
    check("R7 inhibit float", 1'b0, 8'h00);
    do_read(12'h031, 0, "R7 inhibit unchanged");

    // R9 / R10 identifier
    do_sig(12'h000, "R9 maker code");
    do_sig(12'h001, "R9 device code");
    do_sig(12'h201, "R10 bit9 ignored");
    do_sig(12'h004, "R10 bit2 forbidden");
    do_sig(12'h400, "R10 bit10 forbidden");

    // R11 erase blocked and allowed
    do_erase(1);
    do_read(12'h010, 0, "R11 erase blocked by vpp");
    do_erase(0);
    do_read(12'h010, 0, "R11 erase restores FF");
    do_read(12'h020, 0, "R11 erase restores FF 2");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom % 16;
      logic [AW-1:0] a = AW'($urandom % 64);
      if (op < 6) begin
        do_program(a, 8'($urandom), ($urandom % 8) != 0, 1 + ($urandom % 3));
      end else if (op < 12) begin
        do_read(a, $urandom % 2, "R2 random read");
      end else if (op < 14) begin
        logic [AW-1:0] sa = AW'($urandom % 2);
        if ($urandom % 2) sa = sa | AW'(1 << ($urandom % AW));
        do_sig(sa, "R10 random identifier");
      end else if (op == 14) begin
        idle(); ce_n = $urandom % 2; oe_n = 1; addr = a; tick();
        check("R3 random float", 1'b0, 8'h00);
      end else if (($urandom % 8) == 0) begin
        do_erase($urandom % 2);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule